// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block is the control section of a small register-transfer CPU built without microcode. A one-hot step register walks through up to eight control steps per instruction. A purely combinational decoder looks at three things: the active step, the decoded opcode and the negative flag. From these it produces the register-gating strobes, the memory read request, the wait-for-memory request and the end-of-instruction indication. Every instruction shares the same three-step fetch. Steps four onward depend on the opcode: an add of a memory operand, an unconditional relative jump, or a relative jump taken only when the negative flag is set.

Memory signals completion on an input that bears no timing relation to the CPU clock. That input is captured by a single flip-flop on the falling clock edge, so the enable of the step register has half a period to settle before the next rising edge. While a wait-for-memory step is active and the captured completion is low, the enable (RUN) is low and the step register holds. The read request is held from its first step until the captured completion has been consumed. The memory keeps completion high until it sees the read fall.

Top module: `ctl_step_seq`

## Requirements
- R1: While reset is low, step_o is 8'b0000_0001 (T1 active), and wmfc_o and end_o are 0. Reset leaves RUN enabled.
- R2: step_o always has exactly one bit set, where bit k means step T(k+1). When RUN is 1 and end_o is 0, each rising edge moves the set bit up by one.
- R3: While wmfc_o is 1 and the falling-edge capture of mfc_i is 0, step_o does not change on any rising edge.
- R4: Opcode encoding is 0 = none, 1 = add, 2 = jump, 3 = jump-if-negative. wmfc_o is 1 in T2 for every opcode, and also in T5 when the opcode is add.
- R5: end_o is 1 in the following steps: T8 for add; T7 for jump; T7 for jump-if-negative with flag_neg_i = 1; T4 for jump-if-negative with flag_neg_i = 0; T4 for opcode none.
- R6: On the rising edge that ends a step where end_o is 1, step_o returns to T1.
- R7: mfc_i is sampled on the falling clock edge. Once a 1 has been captured during a wait step, the next rising edge advances the step and wmfc_o drops to 0.
- R8: read_o rises in T1 of every instruction and in T4 of add. It stays high through the following wait step and falls on the rising edge that ends the wait.
- R9: pc_in_o is 1 in T2, and in T6 of a jump or of a taken jump-if-negative. It is 0 in all other steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 2 | Decoded opcode from the instruction register |
| flag_neg_i | input | 1 | Negative condition flag |
| mfc_i | input | 1 | Memory completion, asynchronous to clk |
| step_o | output | 8 | One-hot control step T1..T8 |
| end_o | output | 1 | Last step of the instruction |
| wmfc_o | output | 1 | Wait-for-memory request |
| read_o | output | 1 | Memory read request |
| pc_out_o | output | 1 | Drive PC onto the bus |
| pc_in_o | output | 1 | Load PC from the bus |
| mar_in_o | output | 1 | Load memory address register |
| mdr_out_o | output | 1 | Drive memory data register onto the bus |
| ir_in_o | output | 1 | Load instruction register |
| y_in_o | output | 1 | Load ALU operand register Y |
| y_clr_o | output | 1 | Clear Y |
| z_in_o | output | 1 | Load ALU result register Z |
| z_out_o | output | 1 | Drive Z onto the bus |
| alu_add_o | output | 1 | ALU performs addition |
| carry_in_o | output | 1 | Force ALU carry-in |
| gpr_out_o | output | 1 | Drive a general register onto the bus |
| gpr_in_o | output | 1 | Load a general register |
| ofs_out_o | output | 1 | Drive the instruction offset field onto the bus |

## Verification
The assertions assume three things about the environment. The opcode and flag stay stable from T1 until the end of each instruction. mfc_i never changes exactly on a falling clock edge. Memory drops completion within about a cycle after read_o falls, so a stale completion is never visible in the next wait step. The stimulus changes the opcode only when T1 is observed. It raises completion after a random delay of 1 to 30 ns and drops it 0.15 to 1.15 ns after read falls. All delays are offset by 50 ps from the clock grid, so completion arrives at many different phases of the clock without ever landing on an edge.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

  localparam int STEPS = 8;
  localparam int OPW   = 2;

  localparam int T1 = 0;
  localparam int T2 = 1;
  localparam int T3 = 2;
  localparam int T4 = 3;
  localparam int T5 = 4;
  localparam int T6 = 5;
  localparam int T7 = 6;
  localparam int T8 = 7;

  typedef enum logic [OPW-1:0] {
    OP_NONE   = 2'd0,
    OP_ADD    = 2'd1,
    OP_JMP    = 2'd2,
    OP_JMPNEG = 2'd3
  } op_e;

  typedef struct packed {
    logic pc_out;
    logic pc_in;
    logic mar_in;
    logic mdr_out;
    logic ir_in;
    logic y_in;
    logic y_clr;
    logic z_in;
    logic z_out;
    logic alu_add;
    logic carry_in;
    logic gpr_out;
    logic gpr_in;
    logic ofs_out;
  } gate_t;

  typedef struct packed {
    gate_t gate;
    logic  fin;
    logic  wait_mem;
    logic  rd_req;
  } ctl_t;

  // last step of the instruction
  function automatic logic fin_fn(logic [STEPS-1:0] s, op_e op, logic neg);
    logic r;
    r = 1'b0;
    case (op)
      OP_ADD:    r = s[T8];
      OP_JMP:    r = s[T7];
      OP_JMPNEG: r = (s[T7] & neg) | (s[T4] & ~neg);
      default:   r = s[T4];
    endcase
    return r;
  endfunction

  // steps that must wait for memory completion
  function automatic logic wait_fn(logic [STEPS-1:0] s, op_e op);
    return s[T2] | (s[T5] & (op == OP_ADD));
  endfunction

  // steps that start a memory read
  function automatic logic rd_fn(logic [STEPS-1:0] s, op_e op);
    return s[T1] | (s[T4] & (op == OP_ADD));
  endfunction

  function automatic logic taken_fn(op_e op, logic neg);
    return (op == OP_JMP) | ((op == OP_JMPNEG) & neg);
  endfunction

endpackage

// File: rtl/ctl_step_counter.sv
module ctl_step_counter
  import ctl_seq_pkg::*;
#(
  parameter int NSTEP = STEPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  output logic [NSTEP-1:0] step_o
);

  localparam logic [NSTEP-1:0] FIRST = {{(NSTEP-1){1'b0}}, 1'b1};

  logic [NSTEP-1:0] step_q;
  logic [NSTEP-1:0] step_d;

  generate
    for (genvar k = 0; k < NSTEP; k++) begin : g_next
      if (k == 0) begin : g_first
        assign step_d[k] = restart_i | step_q[NSTEP-1];
      end else begin : g_rest
        assign step_d[k] = ~restart_i & step_q[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_q <= FIRST;
    else if (run_i) step_q <= step_d;
  end

  assign step_o = step_q;

  assert_onehot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_q) == 1);

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !restart_i) |=>
      (step_q == {$past(step_q[NSTEP-2:0]), $past(step_q[NSTEP-1])}));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(step_q));

endmodule

// File: rtl/ctl_mfc_sync.sv
module ctl_mfc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic cap_q;

  // falling-edge capture: RUN has half a period to settle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= async_i;
  end

  assign sync_o = cap_q;

endmodule

// File: rtl/ctl_read_hold.sv
module ctl_read_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic release_i,
  output logic read_o
);

  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= (hold_q | req_i) & ~release_i;
  end

  assign read_o = req_i | hold_q;

  assert_hold_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !release_i) |=> read_o);

endmodule

// File: rtl/ctl_step_decode.sv
module ctl_step_decode
  import ctl_seq_pkg::*;
#(
  parameter int NSTEP = STEPS
) (
  input  logic [NSTEP-1:0] step_i,
  input  op_e              op_i,
  input  logic             neg_i,
  output ctl_t             ctl_o
);

  logic  taken;
  logic  is_add;
  gate_t g;

  assign taken  = taken_fn(op_i, neg_i);
  assign is_add = (op_i == OP_ADD);

  always_comb begin
    g = '0;
    // shared fetch: T1 PC to MAR and PC+1 into Z, T2 Z to PC, T3 load IR
    if (step_i[T1]) begin
      g.pc_out   = 1'b1;
      g.mar_in   = 1'b1;
      g.y_clr    = 1'b1;
      g.carry_in = 1'b1;
      g.alu_add  = 1'b1;
      g.z_in     = 1'b1;
    end
    if (step_i[T2]) begin
      g.z_out = 1'b1;
      g.pc_in = 1'b1;
    end
    if (step_i[T3]) begin
      g.mdr_out = 1'b1;
      g.ir_in   = 1'b1;
    end
    // add a memory operand to a register
    if (is_add) begin
      if (step_i[T4]) begin
        g.gpr_out = 1'b1;
        g.mar_in  = 1'b1;
      end
      if (step_i[T5]) begin
        g.gpr_out = 1'b1;
        g.y_in    = 1'b1;
      end
      if (step_i[T6]) begin
        g.mdr_out = 1'b1;
        g.alu_add = 1'b1;
        g.z_in    = 1'b1;
      end
      if (step_i[T7]) begin
        g.z_out  = 1'b1;
        g.gpr_in = 1'b1;
      end
    end
    // relative jump: PC + offset
    if (taken) begin
      if (step_i[T4]) begin
        g.pc_out = 1'b1;
        g.y_in   = 1'b1;
      end
      if (step_i[T5]) begin
        g.ofs_out = 1'b1;
        g.alu_add = 1'b1;
        g.z_in    = 1'b1;
      end
      if (step_i[T6]) begin
        g.z_out = 1'b1;
        g.pc_in = 1'b1;
      end
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o.gate     = g;
    ctl_o.fin      = fin_fn(step_i[STEPS-1:0], op_i, neg_i);
    ctl_o.wait_mem = wait_fn(step_i[STEPS-1:0], op_i);
    ctl_o.rd_req   = rd_fn(step_i[STEPS-1:0], op_i);
  end

endmodule

// File: rtl/ctl_step_seq.sv
module ctl_step_seq
  import ctl_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   opcode_i,
  input  logic             flag_neg_i,
  input  logic             mfc_i,
  output logic [STEPS-1:0] step_o,
  output logic             end_o,
  output logic             wmfc_o,
  output logic             read_o,
  output logic             pc_out_o,
  output logic             pc_in_o,
  output logic             mar_in_o,
  output logic             mdr_out_o,
  output logic             ir_in_o,
  output logic             y_in_o,
  output logic             y_clr_o,
  output logic             z_in_o,
  output logic             z_out_o,
  output logic             alu_add_o,
  output logic             carry_in_o,
  output logic             gpr_out_o,
  output logic             gpr_in_o,
  output logic             ofs_out_o
);

  logic [STEPS-1:0] step;
  ctl_t             ctl;
  op_e              op;
  logic             mfc_s;
  logic             run;
  logic             wait_done;
  logic             rd;

  assign op = op_e'(opcode_i);

  ctl_mfc_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(mfc_i),
    .sync_o (mfc_s)
  );

  ctl_step_decode #(.NSTEP(STEPS)) u_dec (
    .step_i(step),
    .op_i  (op),
    .neg_i (flag_neg_i),
    .ctl_o (ctl)
  );

  // RUN drops while a wait step has no captured completion
  assign run       = ~ctl.wait_mem | mfc_s;
  assign wait_done = ctl.wait_mem & mfc_s;

  ctl_step_counter #(.NSTEP(STEPS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .restart_i(ctl.fin),
    .step_o   (step)
  );

  ctl_read_hold u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (ctl.rd_req),
    .release_i(wait_done),
    .read_o   (rd)
  );

  assign step_o     = step;
  assign end_o      = ctl.fin;
  assign wmfc_o     = ctl.wait_mem;
  assign read_o     = rd;
  assign pc_out_o   = ctl.gate.pc_out;
  assign pc_in_o    = ctl.gate.pc_in;
  assign mar_in_o   = ctl.gate.mar_in;
  assign mdr_out_o  = ctl.gate.mdr_out;
  assign ir_in_o    = ctl.gate.ir_in;
  assign y_in_o     = ctl.gate.y_in;
  assign y_clr_o    = ctl.gate.y_clr;
  assign z_in_o     = ctl.gate.z_in;
  assign z_out_o    = ctl.gate.z_out;
  assign alu_add_o  = ctl.gate.alu_add;
  assign carry_in_o = ctl.gate.carry_in;
  assign gpr_out_o  = ctl.gate.gpr_out;
  assign gpr_in_o   = ctl.gate.gpr_in;
  assign ofs_out_o  = ctl.gate.ofs_out;

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc_o && !mfc_s) |=> $stable(step_o));

  assert_wait_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc_o && mfc_s) |=> (!wmfc_o && (step_o != $past(step_o))));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> step_o[T1]);

  assert_read_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wmfc_o |-> read_o);

  assert_read_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc_o && mfc_s) |=> !read_o);

  assert_no_end_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_o && wmfc_o));

endmodule

// File: tb/ctl_step_seq_tb.sv
`timescale 1ns/1ps
module ctl_step_seq_tb_top;

  typedef struct {
    int step;
    bit rd;
    bit wm;
    bit en;
    bit pcin;
    int op;
    bit n;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] opcode = 2'd0;
  logic       flag_n = 1'b0;
  logic       mfc = 1'b0;
  logic [7:0] step;
  logic end_s, wmfc_s, read_s;
  logic pc_out, pc_in, mar_in, mdr_out, ir_in, y_in, y_clr, z_in, z_out;
  logic alu_add, carry_in, gpr_out, gpr_in, ofs_out;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  bit   mfc_neg = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  ctl_step_seq dut_i (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .flag_neg_i(flag_n), .mfc_i(mfc),
    .step_o(step), .end_o(end_s), .wmfc_o(wmfc_s), .read_o(read_s),
    .pc_out_o(pc_out), .pc_in_o(pc_in), .mar_in_o(mar_in), .mdr_out_o(mdr_out),
    .ir_in_o(ir_in), .y_in_o(y_in), .y_clr_o(y_clr), .z_in_o(z_in), .z_out_o(z_out),
    .alu_add_o(alu_add), .carry_in_o(carry_in), .gpr_out_o(gpr_out),
    .gpr_in_o(gpr_in), .ofs_out_o(ofs_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int step_num(input logic [7:0] s);
    int n;
    n = -1;
    if ($countones(s) == 1)
      for (int k = 0; k < 8; k++) if (s[k]) n = k + 1;
    return n;
  endfunction

  // driver: expected step list of one instruction
  task automatic push_instr(input int op, input bit n);
    int len;
    exp_t e;
    case (op)
      1: len = 8;
      2: len = 7;
      3: len = n ? 7 : 4;
      default: len = 4;
    endcase
    for (int s = 1; s <= len; s++) begin
      e.step = s;
      e.rd   = (s == 1) || (s == 2) || (op == 1 && (s == 4 || s == 5));
      e.wm   = (s == 2) || (op == 1 && s == 5);
      e.en   = (s == len);
      e.pcin = (s == 2) || (s == 6 && (op == 2 || (op == 3 && n)));
      e.op   = op;
      e.n    = n;
      q.push_back(e);
    end
  endtask

  // memory model: completion at a random phase, dropped soon after read falls
  initial begin
    forever begin
      wait (read_s === 1'b1);
      #($urandom_range(10, 300) * 0.1 + 0.05);
      mfc = 1'b1;
      wait (read_s === 1'b0);
      #($urandom_range(1, 11) * 0.1 + 0.05);
      mfc = 1'b0;
    end
  end

  always @(negedge clk) mfc_neg = mfc;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  // stimulus and monitor
  initial begin
    logic [7:0] prev_step;
    bit         prev_wm;
    bit         prev_en;
    bit         first;
    exp_t       e;
    int         sn;

    push_instr(1, 1'b0);
    push_instr(2, 1'b0);
    push_instr(3, 1'b1);
    push_instr(3, 1'b0);
    push_instr(0, 1'b0);
    push_instr(1, 1'b1);
    for (int i = 0; i < 40; i++) push_instr($urandom_range(0, 3), 1'($urandom_range(0, 1)));

    repeat (5) @(posedge clk);
    #1;
    chk(step == 8'h01, "R1", "step in reset", step, 1);
    chk(wmfc_s == 1'b0, "R1", "wmfc in reset", wmfc_s, 0);
    chk(end_s == 1'b0, "R1", "end in reset", end_s, 0);
    rst_n = 1'b1;

    first = 1'b1;
    prev_step = '0;
    prev_wm = 1'b0;
    prev_en = 1'b0;
    while (q.size() != 0) begin
      if (!first) begin
        @(posedge clk);
        #1;
      end
      sn = step_num(step);
      chk(sn > 0, "R2", "step one-hot", step, 1);
      if (!first && prev_wm && !mfc_neg) begin
        chk(step == prev_step, "R3", "step held during wait", step, prev_step);
        chk(wmfc_s == 1'b1, "R4", "wmfc stays during wait", wmfc_s, 1);
        chk(read_s == 1'b1, "R8", "read held during wait", read_s, 1);
      end else begin
        e = q.pop_front();
        if (e.step == 1) begin
          opcode = 2'(e.op);
          flag_n = e.n;
        end
        if (!first && prev_wm)
          chk(sn == e.step && wmfc_s == 1'b0, "R7", "advance after completion", sn, e.step);
        else if (!first && prev_en)
          chk(sn == 1, "R6", "return to T1 after end", sn, 1);
        else
          chk(sn == e.step, "R2", "step advance", sn, e.step);
        chk(wmfc_s == e.wm, "R4", "wmfc", wmfc_s, e.wm);
        chk(end_s == e.en, "R5", "end", end_s, e.en);
        chk(read_s == e.rd, "R8", "read", read_s, e.rd);
        chk(pc_in == e.pcin, "R9", "pc_in", pc_in, e.pcin);
      end
      prev_step = step;
      prev_wm = wmfc_s;
      prev_en = end_s;
      first = 1'b0;
    end
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule